// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is a single 32-bit timer channel controlled through six word-addressed registers. Software loads a compare value, a clock-divider value and control options, then sets the enable bit. While the channel is active, a prescaler counts input clock cycles. Each time the prescaler reaches the divider value, the count register advances by one. When the advanced count equals the compare value, the channel times out. A timeout sets the status flag and, if interrupts are enabled, asserts a level interrupt. The interrupt goes either to the normal line or, when NMI routing is selected, to the non-maskable line. On a timeout the channel either reloads the count with zero and keeps running, or stops with the count equal to the compare value.

Some edge rules govern enabling and clearing. Enabling with count and compare both zero gives an immediate timeout. Any other enable takes one step in the same cycle. In interval mode, an attempt to clear the flag is refused while count equals compare. In interval mode, raising the interrupt-enable bit while the flag is set fires the interrupt at once.

Top module: `cmt_channel`

## Requirements
- R1: After reset, every register reads zero and both `irq_o` and `nmi_o` are low. The word offsets are: count 0, compare 1, enable 2 (bit 0), control 3, status 4 (bit 0), divider 5. Offsets 6 and 7 read zero.
- R2: Writing 1 to the enable bit while it is already 1 changes nothing. The prescaler is not restarted and no extra step is taken.
- R3: Writing 1 to the enable bit while it is 0, with count and compare both zero, causes a timeout in that cycle. The status flag is set, the selected interrupt is raised if enabled, and enable stays 0 with count unchanged.
- R4: Any other 0-to-1 enable write makes the channel active and takes one prescaler step in the write cycle itself.
- R5: An active channel advances the count once every divider+1 clock cycles. A divider value of 0 advances it every cycle.
- R6: A timeout happens when the advanced count equals compare. It sets the status flag. It raises the interrupt only when control bit 0 (interrupt enable) is 1. With control bit 1 (auto-reload) at 0, the channel stops: enable reads 0 and count equals compare.
- R7: With auto-reload at 1, a timeout sets count to 0 and the channel keeps running. A write of 0 to the enable bit stops the channel, and no step is taken in the cycle of that write.
- R8: Writing 0 to the status bit is ignored when control bit 2 (mode) is 0 and count equals compare. In every other case the write clears the flag and drops both interrupt outputs.
- R9: A control write that changes interrupt enable from 0 to 1, with mode 0 in the written word, raises the interrupt at once if the status flag is set.
- R10: With control bit 3 (NMI select) at 1, a raise drives `nmi_o` high and `irq_o` low. With it at 0, a raise drives `irq_o` high and `nmi_o` low. The two outputs are never high together.
- R11: Writing 1 to the status bit sets the flag. It also raises the selected interrupt when interrupt enable is 1.
- R12: A read presents `rd_valid_o` and `rdata_o` at the clock edge after the one that samples `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| irq_o | output | 1 | Level interrupt, held until cleared |
| nmi_o | output | 1 | Non-maskable interrupt, held until cleared |

## Verification
Read data is due one edge after the read strobe. The driver queues the expected word, and the monitor pops it on the falling edge after `rd_valid_o` rises, so no compare depends on wait counts.

Interrupt pins are registered. A write-triggered raise (R3, R4, R9, R11) is therefore sampled on the falling edge right after the write edge. The divider case is sampled one cycle before and one cycle on the (divider+1)·compare-th edge counted from the enable write. Free-running auto-reload is checked through the count it holds after a disable placed a known number of edges after enable.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd5;

  localparam int unsigned CTRL_W = 4;

  // bit 3 nmi select, bit 2 mode, bit 1 auto-reload, bit 0 interrupt enable
  typedef struct packed {
    logic nmi_sel;
    logic mode;
    logic auto_rl;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             adv_o
);
  logic [DIV_W-1:0] pre_q;

  assign adv_o = step_i && (pre_q == div_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q <= '0;
    end else if (!step_i || adv_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_cnt_i,
  input  logic             wr_cmp_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             adv_i,
  input  logic             auto_rl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             match_o,
  output logic             both_zero_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_inc;

  assign cnt_inc     = cnt_q + CNT_W'(1);
  assign hit_o       = adv_i && !wr_cnt_i && (cnt_inc == cmp_q);
  assign match_o     = (cnt_q == cmp_q);
  assign both_zero_o = (cnt_q == '0) && (cmp_q == '0);
  assign cnt_o       = cnt_q;
  assign cmp_o       = cmp_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_cmp_i) cmp_q <= wdata_i;
      if (wr_cnt_i) begin
        cnt_q <= wdata_i;
      end else if (adv_i) begin
        cnt_q <= (hit_o && auto_rl_i) ? '0 : cnt_inc;
      end
    end
  end
endmodule

// File: rtl/cmt_irq.sv
module cmt_irq
  import cmt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  tmo_i,
  input  logic  wr_stat_i,
  input  logic  stat_bit_i,
  input  logic  wr_ctrl_i,
  input  ctrl_t ctrl_new_i,
  input  ctrl_t ctrl_q_i,
  input  logic  match_i,
  output logic  status_o,
  output logic  irq_o,
  output logic  nmi_o
);
  logic status_q, irq_q, nmi_q;
  logic sw_set, clr_ok, ie_rise, raise, route_nmi;

  assign sw_set  = wr_stat_i && stat_bit_i;
  assign clr_ok  = wr_stat_i && !stat_bit_i && (ctrl_q_i.mode || !match_i) && !tmo_i;
  assign ie_rise = wr_ctrl_i && ctrl_new_i.ie && !ctrl_q_i.ie && !ctrl_new_i.mode && status_q;
  assign raise   = ((tmo_i || sw_set) && ctrl_q_i.ie) || ie_rise;
  assign route_nmi = wr_ctrl_i ? ctrl_new_i.nmi_sel : ctrl_q_i.nmi_sel;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      if (tmo_i || sw_set) begin
        status_q <= 1'b1;
      end else if (clr_ok) begin
        status_q <= 1'b0;
      end
      if (raise) begin
        irq_q <= !route_nmi;
        nmi_q <= route_nmi;
      end else if (clr_ok) begin
        irq_q <= 1'b0;
        nmi_q <= 1'b0;
      end
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
  assign nmi_o    = nmi_q;
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  output logic              irq_o,
  output logic              nmi_o
);
  localparam int unsigned PAD_CTRL = DATA_W - CTRL_W;
  localparam int unsigned PAD_BIT  = DATA_W - 1;

  logic wr_cnt, wr_cmp, wr_en, wr_ctrl, wr_stat, wr_div;
  logic en_q, start, imm_tmo, stop_sw, step, adv, hit, match, both_zero, tmo;
  logic status_w;
  ctrl_t ctrl_q, ctrl_new;
  logic [DATA_W-1:0] div_q, cnt_w, cmp_w, rdata_q;
  logic rd_valid_q;

  assign wr_cnt  = wr_i && (addr_i == OFS_CNT);
  assign wr_cmp  = wr_i && (addr_i == OFS_CMP);
  assign wr_en   = wr_i && (addr_i == OFS_EN);
  assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
  assign wr_stat = wr_i && (addr_i == OFS_STAT);
  assign wr_div  = wr_i && (addr_i == OFS_DIV);
  assign ctrl_new = ctrl_t'(wdata_i[CTRL_W-1:0]);

  assign imm_tmo = wr_en && wdata_i[0] && !en_q && both_zero;
  assign start   = wr_en && wdata_i[0] && !en_q && !both_zero;
  assign stop_sw = wr_en && !wdata_i[0];
  assign step    = (en_q && !stop_sw) || start;
  assign tmo     = hit || imm_tmo;

  cmt_prescaler #(.DIV_W(DATA_W)) i_pre (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .step_i(step),
    .div_i (div_q),
    .adv_o (adv)
  );

  cmt_counter #(.CNT_W(DATA_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_cnt_i   (wr_cnt),
    .wr_cmp_i   (wr_cmp),
    .wdata_i    (wdata_i),
    .adv_i      (adv),
    .auto_rl_i  (ctrl_q.auto_rl),
    .cnt_o      (cnt_w),
    .cmp_o      (cmp_w),
    .hit_o      (hit),
    .match_o    (match),
    .both_zero_o(both_zero)
  );

  cmt_irq i_irq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tmo_i     (tmo),
    .wr_stat_i (wr_stat),
    .stat_bit_i(wdata_i[0]),
    .wr_ctrl_i (wr_ctrl),
    .ctrl_new_i(ctrl_new),
    .ctrl_q_i  (ctrl_q),
    .match_i   (match),
    .status_o  (status_w),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q   <= 1'b0;
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_div)  div_q  <= wdata_i;
      if (stop_sw || (hit && !ctrl_q.auto_rl)) begin
        en_q <= 1'b0;
      end else if (start) begin
        en_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_i;
      if (rd_i) begin
        case (addr_i)
          OFS_CNT:  rdata_q <= cnt_w;
          OFS_CMP:  rdata_q <= cmp_w;
          OFS_EN:   rdata_q <= {{PAD_BIT{1'b0}}, en_q};
          OFS_CTRL: rdata_q <= {{PAD_CTRL{1'b0}}, ctrl_q};
          OFS_STAT: rdata_q <= {{PAD_BIT{1'b0}}, status_w};
          OFS_DIV:  rdata_q <= div_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk
  import cmt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_valid_o,
  input logic              irq_o,
  input logic              nmi_o,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      cmp,
  input logic              en,
  input logic              status
);
  a_r10_one_line: assert property (@(posedge clk_i) disable iff (rst_i)
    !(irq_o && nmi_o));

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o || nmi_o) |-> status);

  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(status) |-> (!irq_o && !nmi_o));

  a_r5_count_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_i && addr_i == OFS_CNT) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + W'(1) || cnt == '0));

  a_r6_stop_at_cmp: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(en) && !$past(wr_i && (addr_i == OFS_EN || addr_i == OFS_CNT || addr_i == OFS_CMP)))
      |-> (cnt == cmp));

  a_r12_read_due: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> rd_valid_o);

  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> !rd_valid_o);
endmodule

bind cmt_channel cmt_channel_chk #(.W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rd_valid_o(rd_valid_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .cnt       (cnt_w),
  .cmp       (cmp_w),
  .en        (en_q),
  .status    (status_w)
);

// File: tb/test_cmt_channel.sv
module test_cmt_channel;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr = 1'b0, rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rd_valid, irq, nmi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_channel #(.DATA_W(DW)) i_cmt_channel (
    .clk_i(clk), .rst_i(rst), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .irq_o(irq), .nmi_o(nmi)
  );

  // driver: all tasks start and end just after a falling edge
  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic check_pin(input logic act, input logic e, input string tag);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, e);
    end
  endtask

  // monitor: pops expected read data as the design produces it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12: unexpected read data %0h, expected none", rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s: got %0h expected %0h", t, rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R12 read timing
    for (int i = 0; i < 8; i++) rreg(3'(i), '0, "R1 reset register");
    check_pin(irq, 1'b0, "R1 irq at reset");
    check_pin(nmi, 1'b0, "R1 nmi at reset");

    // R4 start step: cmp=1, div=0 -> timeout on the enable edge
    wreg(3'd1, 32'd1);
    wreg(3'd3, 32'h1);
    wreg(3'd2, 32'h1);
    check_pin(irq, 1'b1, "R4 irq right after enable");
    rreg(3'd2, 32'd0, "R6 enable cleared on stop");
    rreg(3'd0, 32'd1, "R6 count equals compare");
    rreg(3'd4, 32'd1, "R6 status set");

    // R8 clear refused in mode 0 while count==compare
    wreg(3'd4, 32'd0);
    rreg(3'd4, 32'd1, "R8 clear ignored on match");
    check_pin(irq, 1'b1, "R8 irq held on ignored clear");
    wreg(3'd0, 32'd0);
    wreg(3'd4, 32'd0);
    rreg(3'd4, 32'd0, "R8 clear accepted");
    check_pin(irq, 1'b0, "R8 irq dropped");

    // R5 divider 2, compare 2: irq due on the 6th edge from enable
    wreg(3'd5, 32'd2);
    wreg(3'd1, 32'd2);
    wreg(3'd2, 32'h1);
    repeat (4) @(negedge clk);
    check_pin(irq, 1'b0, "R5 no timeout yet");
    @(negedge clk);
    check_pin(irq, 1'b1, "R5 timeout after divided steps");
    rreg(3'd0, 32'd2, "R5 final count");

    // R2 re-enable while running has no effect
    wreg(3'd0, 32'd0);
    wreg(3'd4, 32'd0);
    wreg(3'd5, 32'd1);
    wreg(3'd1, 32'd1000);
    wreg(3'd3, 32'h0);
    wreg(3'd2, 32'h1);
    wreg(3'd2, 32'h1);
    wreg(3'd2, 32'h0);
    rreg(3'd0, 32'd1, "R2 count after rewrite");

    // R7 auto-reload, cmp=4, 11 steps before the disable edge
    wreg(3'd0, 32'd0);
    wreg(3'd1, 32'd4);
    wreg(3'd5, 32'd0);
    wreg(3'd3, 32'h3);
    wreg(3'd2, 32'h1);
    repeat (9) @(negedge clk);
    rreg(3'd2, 32'd1, "R7 still enabled after reload");
    wreg(3'd2, 32'h0);
    rreg(3'd0, 32'd3, "R7 count wrapped");
    rreg(3'd4, 32'd1, "R7 status set");
    check_pin(irq, 1'b1, "R7 irq asserted");

    // R8 mode 1 clears even on match, R11 software set
    wreg(3'd3, 32'h4);
    wreg(3'd0, 32'd4);
    wreg(3'd4, 32'd0);
    rreg(3'd4, 32'd0, "R8 mode 1 clear on match");
    check_pin(irq, 1'b0, "R8 mode 1 irq dropped");
    wreg(3'd3, 32'h5);
    wreg(3'd4, 32'd1);
    check_pin(irq, 1'b1, "R11 set raises irq");
    rreg(3'd4, 32'd1, "R11 status set by write");

    // R9 interrupt-enable rise
    wreg(3'd3, 32'h4);
    wreg(3'd4, 32'd0);
    wreg(3'd4, 32'd1);
    check_pin(irq, 1'b0, "R11 no raise with ie off");
    wreg(3'd3, 32'h5);
    check_pin(irq, 1'b0, "R9 no raise in mode 1");
    wreg(3'd3, 32'h4);
    wreg(3'd3, 32'h1);
    check_pin(irq, 1'b1, "R9 raise on ie rise");

    // R10 NMI routing with R3 immediate timeout
    wreg(3'd3, 32'h4);
    wreg(3'd4, 32'd0);
    check_pin(irq, 1'b0, "R8 cleared before nmi test");
    wreg(3'd0, 32'd0);
    wreg(3'd1, 32'd0);
    wreg(3'd3, 32'h9);
    wreg(3'd2, 32'h1);
    check_pin(nmi, 1'b1, "R10 nmi raised");
    check_pin(irq, 1'b0, "R10 irq stays low");
    rreg(3'd4, 32'd1, "R3 status set immediately");
    rreg(3'd2, 32'd0, "R3 enable stays clear");
    rreg(3'd0, 32'd0, "R3 count unchanged");
    rreg(3'd3, 32'h9, "R1 control readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R12: %0d reads never returned, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule